// File: doc/BRIEF.md
# Receive Mailbox Allocation Bank

This block is a bank of sixteen message mailboxes. It sits behind a CAN receive path that has already assembled and validated each frame. For every frame that arrives, the bank picks one mailbox and stores the identifier, the length code, the remote flag and the eight data bytes there. The mailbox it picks is the lowest-numbered one that is set for reception, accepts the frame's identifier format, and is currently empty. A filled mailbox raises its ready flag and stays closed until software re-arms it.

Software configures the bank through a simple word-addressed read/write port. Through this port it sets each mailbox's mode and identifier-format flag, reads the captured frames, and re-arms any group of mailboxes with one bitmask write. A mailbox in overwrite mode takes a frame even when it is full, and marks the loss with a flag. When no mailbox can take a frame, the frame is dropped and a sticky overrun flag records the loss.

Top module: `rxmbx_top`

Address map (word addresses):
- 0x00 holds the ready summary (read-only).
- 0x01 holds the overrun flag.
- 0x02 is the re-arm command (write-only).
- Mailbox `i` occupies 0x40 + 8·i. Within it, offset 0 is mode, 1 is identifier, 2 is status, 3 is data bytes 0–3 and 4 is data bytes 4–7.

## Requirements
- R1: After reset, every mailbox is disabled, with mode 0 and an all-zero status word. The summary register and the overrun flag both read zero.
- R2: The mode field sits at bits 26:24 of a mailbox's mode word. Its encodings are 0 off, 1 receive, 2 receive-with-overwrite, 3 transmit, 4 consumer and 5 producer. Only modes 1 and 2 ever capture a frame, and the mode word reads back as written.
- R3: An incoming frame goes into the empty, eligible mailbox with the smallest index, and into no other mailbox.
- R4: A mailbox is eligible only if bit 29 of its identifier word (the extended flag) equals the frame's extended flag.
- R5: On capture, the identifier word takes the frame's format. An extended frame stores bit 29 = 1 and the 29-bit ID at bits 28:0. A standard frame stores bit 29 = 0 and the 11-bit ID at bits 28:18. Data word 0 holds bytes 0–3, with byte 0 in bits 7:0, and data word 1 holds bytes 4–7.
- R6: In the status word, bit 23 is ready, bit 20 is the remote flag and bits 19:16 are the length code. Ready is set on capture. A ready mailbox that is not in overwrite mode takes no further frame.
- R7: If no empty mailbox is eligible, the lowest eligible full overwrite-mode mailbox takes the frame and sets its lost flag (status bit 24).
- R8: If no mailbox can take the frame, the frame is dropped and the overrun flag (bit 0 at 0x01) is set. The flag stays set until a write of 1 to that bit.
- R9: Writing a bitmask to 0x02 clears ready and lost in every mailbox whose bit is set. A capture into the same mailbox in the same cycle takes precedence.
- R10: Bit i of the summary register at 0x00 equals the ready flag of mailbox i.
- R11: Writes to a status word have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frmValid | input | 1 | One-cycle strobe: a received frame is presented |
| frmExt | input | 1 | Frame uses a 29-bit identifier |
| frmId | input | 29 | Identifier; a standard frame uses bits 10:0 |
| frmRtr | input | 1 | Remote-request frame |
| frmLen | input | 4 | Length code |
| frmData | input | 64 | Payload, byte 0 in bits 7:0 |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 8 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |

## Verification
The assertions assume that `frmValid` is a single-cycle strobe and that a frame and a re-arm command for the same mailbox rarely coincide. For that reason, the re-arm property is checked only in cycles without a frame. The bench keeps to this assumption: it presents each frame for one cycle and issues each register write in a cycle of its own. Frames go into a fixed configuration that mixes standard, extended, overwrite and transmit mailboxes, so the bench reaches every allocation outcome: a free slot, an overwrite and a drop.

// File: rtl/rxmbx_pkg.sv
package rxmbx_pkg;

  parameter int unsigned MbxNum = 16;
  localparam int unsigned IdxW = $clog2(MbxNum);
  localparam int unsigned AddrW = 8;
  localparam int unsigned DataW = 32;
  localparam int unsigned SlotShift = 3;
  localparam int unsigned SlotSpan = 1 << SlotShift;

  typedef enum logic [2:0] {
    MODE_OFF   = 3'd0,
    MODE_RX    = 3'd1,
    MODE_RXOVR = 3'd2,
    MODE_TX    = 3'd3,
    MODE_CONS  = 3'd4,
    MODE_PROD  = 3'd5
  } mbxMode_e;

  localparam logic [AddrW-1:0] ADDR_SUMMARY = 8'h00;
  localparam logic [AddrW-1:0] ADDR_OVERRUN = 8'h01;
  localparam logic [AddrW-1:0] ADDR_REARM   = 8'h02;
  localparam logic [AddrW-1:0] ADDR_MBX_BASE = 8'h40;

  localparam logic [SlotShift-1:0] OFS_MODE = 3'd0;
  localparam logic [SlotShift-1:0] OFS_ID   = 3'd1;
  localparam logic [SlotShift-1:0] OFS_STAT = 3'd2;
  localparam logic [SlotShift-1:0] OFS_DLO  = 3'd3;
  localparam logic [SlotShift-1:0] OFS_DHI  = 3'd4;

  localparam int unsigned BitExt  = 29;
  localparam int unsigned BitLost = 24;
  localparam int unsigned BitRdy  = 23;
  localparam int unsigned BitRtr  = 20;
  localparam int unsigned LenLsb  = 16;
  localparam int unsigned ModeLsb = 24;
  localparam int unsigned StdLsb  = 18;

  typedef struct packed {
    logic        ext;
    logic [28:0] id;
    logic        rtr;
    logic [3:0]  len;
    logic [63:0] data;
  } rxFrame_t;

  typedef struct packed {
    logic [MbxNum-1:0] capSel;
    logic              capLost;
    logic              ovrSet;
    logic              ovrClr;
    logic [MbxNum-1:0] rearm;
    logic [MbxNum-1:0] modeWr;
    logic [MbxNum-1:0] idWr;
  } mbxStrobe_t;

  function automatic logic isSlotAddr(input logic [AddrW-1:0] a);
    return (int'(a) >= int'(ADDR_MBX_BASE)) &&
           (int'(a) < int'(ADDR_MBX_BASE) + int'(MbxNum * SlotSpan));
  endfunction

  function automatic logic [IdxW-1:0] slotOf(input logic [AddrW-1:0] a);
    logic [AddrW-1:0] rel;
    rel = a - ADDR_MBX_BASE;
    return rel[SlotShift +: IdxW];
  endfunction

endpackage

// File: rtl/rxmbx_lowest.sv
module rxmbx_lowest #(
  parameter int unsigned Width = 16
) (
  input  logic [Width-1:0] req,
  output logic [Width-1:0] grant,
  output logic             any
);
  assign grant = req & (~req + {{(Width-1){1'b0}}, 1'b1});
  assign any   = |req;
endmodule

// File: rtl/rxmbx_ctrl.sv
module rxmbx_ctrl
  import rxmbx_pkg::*;
(
  input  logic                     frmValid,
  input  logic                     frmExt,
  input  logic [MbxNum-1:0][2:0]   modeVec,
  input  logic [MbxNum-1:0]        extVec,
  input  logic [MbxNum-1:0]        readyVec,
  input  logic                     busWrEn,
  input  logic [AddrW-1:0]         busAddr,
  input  logic [MbxNum-1:0]        wrBits,
  output mbxStrobe_t               stb
);

  logic [MbxNum-1:0] freeReq;
  logic [MbxNum-1:0] ovrReq;
  logic [MbxNum-1:0] freeGrant;
  logic [MbxNum-1:0] ovrGrant;
  logic              freeAny;
  logic              ovrAny;

  for (genvar i = 0; i < MbxNum; i++) begin : g_elig
    logic isRx;
    logic isOvr;
    logic extOk;
    assign isOvr = (modeVec[i] == MODE_RXOVR);
    assign isRx  = (modeVec[i] == MODE_RX) || isOvr;
    assign extOk = (extVec[i] == frmExt);
    assign freeReq[i] = isRx && extOk && !readyVec[i];
    assign ovrReq[i]  = isOvr && extOk && readyVec[i];
  end

  rxmbx_lowest #(.Width(MbxNum)) i_freePick (
    .req   (freeReq),
    .grant (freeGrant),
    .any   (freeAny)
  );

  rxmbx_lowest #(.Width(MbxNum)) i_ovrPick (
    .req   (ovrReq),
    .grant (ovrGrant),
    .any   (ovrAny)
  );

  logic              slotHit;
  logic [IdxW-1:0]   slotIdx;
  logic [SlotShift-1:0] slotOfs;

  assign slotHit = isSlotAddr(busAddr);
  assign slotIdx = slotOf(busAddr);
  assign slotOfs = busAddr[SlotShift-1:0];

  always_comb begin
    stb = '0;
    if (frmValid) begin
      if (freeAny) begin
        stb.capSel = freeGrant;
      end else if (ovrAny) begin
        stb.capSel  = ovrGrant;
        stb.capLost = 1'b1;
      end else begin
        stb.ovrSet = 1'b1;
      end
    end
    if (busWrEn) begin
      if (busAddr == ADDR_REARM) begin
        stb.rearm = wrBits;
      end
      if (busAddr == ADDR_OVERRUN) begin
        stb.ovrClr = wrBits[0];
      end
      if (slotHit) begin
        stb.modeWr[slotIdx] = (slotOfs == OFS_MODE);
        stb.idWr[slotIdx]   = (slotOfs == OFS_ID);
      end
    end
  end

endmodule

// File: rtl/rxmbx_datapath.sv
module rxmbx_datapath
  import rxmbx_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  mbxStrobe_t              stb,
  input  rxFrame_t                frame,
  input  logic [AddrW-1:0]        busAddr,
  input  logic [DataW-1:0]        busWdata,
  output logic [DataW-1:0]        busRdata,
  output logic [MbxNum-1:0][2:0]  modeVec,
  output logic [MbxNum-1:0]       extVec,
  output logic [MbxNum-1:0]       readyVec,
  output logic                    overrunFlag
);

  logic [2:0]       modeQ [MbxNum];
  logic [DataW-1:0] idQ   [MbxNum];
  logic             lostQ [MbxNum];
  logic             rtrQ  [MbxNum];
  logic [3:0]       lenQ  [MbxNum];
  logic [DataW-1:0] dloQ  [MbxNum];
  logic [DataW-1:0] dhiQ  [MbxNum];
  logic             overrunQ;

  logic [DataW-1:0] capId;

  always_comb begin
    if (frame.ext) begin
      capId = {2'b00, 1'b1, frame.id};
    end else begin
      capId = '0;
      capId[StdLsb +: 11] = frame.id[10:0];
    end
  end

  for (genvar i = 0; i < MbxNum; i++) begin : g_mbx
    logic readyQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        modeQ[i]  <= MODE_OFF;
        idQ[i]    <= '0;
        readyQ    <= 1'b0;
        lostQ[i]  <= 1'b0;
        rtrQ[i]   <= 1'b0;
        lenQ[i]   <= '0;
        dloQ[i]   <= '0;
        dhiQ[i]   <= '0;
      end else begin
        if (stb.modeWr[i]) begin
          modeQ[i] <= busWdata[ModeLsb +: 3];
        end
        if (stb.capSel[i]) begin
          idQ[i]   <= capId;
          readyQ   <= 1'b1;
          lostQ[i] <= lostQ[i] | stb.capLost;
          rtrQ[i]  <= frame.rtr;
          lenQ[i]  <= frame.len;
          dloQ[i]  <= frame.data[31:0];
          dhiQ[i]  <= frame.data[63:32];
        end else begin
          if (stb.idWr[i]) begin
            idQ[i] <= busWdata;
          end
          if (stb.rearm[i]) begin
            readyQ   <= 1'b0;
            lostQ[i] <= 1'b0;
          end
        end
      end
    end

    assign modeVec[i]  = modeQ[i];
    assign extVec[i]   = idQ[i][BitExt];
    assign readyVec[i] = readyQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overrunQ <= 1'b0;
    end else if (stb.ovrSet) begin
      overrunQ <= 1'b1;
    end else if (stb.ovrClr) begin
      overrunQ <= 1'b0;
    end
  end

  assign overrunFlag = overrunQ;

  logic [IdxW-1:0]      rdIdx;
  logic [SlotShift-1:0] rdOfs;
  logic [DataW-1:0]     statWord;

  assign rdIdx = slotOf(busAddr);
  assign rdOfs = busAddr[SlotShift-1:0];

  always_comb begin
    statWord = '0;
    statWord[BitLost]       = lostQ[rdIdx];
    statWord[BitRdy]        = readyVec[rdIdx];
    statWord[BitRtr]        = rtrQ[rdIdx];
    statWord[LenLsb +: 4]   = lenQ[rdIdx];
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_SUMMARY) begin
      busRdata[MbxNum-1:0] = readyVec;
    end else if (busAddr == ADDR_OVERRUN) begin
      busRdata[0] = overrunQ;
    end else if (isSlotAddr(busAddr)) begin
      case (rdOfs)
        OFS_MODE: busRdata[ModeLsb +: 3] = modeQ[rdIdx];
        OFS_ID:   busRdata = idQ[rdIdx];
        OFS_STAT: busRdata = statWord;
        OFS_DLO:  busRdata = dloQ[rdIdx];
        OFS_DHI:  busRdata = dhiQ[rdIdx];
        default:  busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/rxmbx_top.sv
module rxmbx_top
  import rxmbx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frmValid,
  input  logic              frmExt,
  input  logic [28:0]       frmId,
  input  logic              frmRtr,
  input  logic [3:0]        frmLen,
  input  logic [63:0]       frmData,
  input  logic              busWrEn,
  input  logic [AddrW-1:0]  busAddr,
  input  logic [DataW-1:0]  busWdata,
  output logic [DataW-1:0]  busRdata
);

  rxFrame_t                frame;
  mbxStrobe_t              stb;
  logic [MbxNum-1:0][2:0]  modeVec;
  logic [MbxNum-1:0]       extVec;
  logic [MbxNum-1:0]       readyVec;
  logic                    overrunFlag;

  assign frame = '{ext: frmExt, id: frmId, rtr: frmRtr, len: frmLen, data: frmData};

  rxmbx_ctrl i_ctrl (
    .frmValid (frmValid),
    .frmExt   (frmExt),
    .modeVec  (modeVec),
    .extVec   (extVec),
    .readyVec (readyVec),
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .wrBits   (busWdata[MbxNum-1:0]),
    .stb      (stb)
  );

  rxmbx_datapath i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .frame       (frame),
    .busAddr     (busAddr),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .modeVec     (modeVec),
    .extVec      (extVec),
    .readyVec    (readyVec),
    .overrunFlag (overrunFlag)
  );

endmodule

// File: rtl/rxmbx_checker.sv
module rxmbx_checker
  import rxmbx_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              frmValid,
  input logic              busWrEn,
  input logic [AddrW-1:0]  busAddr,
  input logic [MbxNum-1:0] wrBits,
  input logic [MbxNum-1:0] sumBits,
  input logic [MbxNum-1:0] readyVec,
  input logic              overrunFlag
);

  logic rearmCmd;
  logic ovrClrCmd;
  assign rearmCmd  = busWrEn && (busAddr == ADDR_REARM);
  assign ovrClrCmd = busWrEn && (busAddr == ADDR_OVERRUN) && wrBits[0];

  AST_ONE_SLOT_PER_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |=> $countones(readyVec & ~$past(readyVec)) <= 1); // R3

  AST_READY_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    !frmValid |=> ((readyVec & ~$past(readyVec)) == '0)); // R6

  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !rearmCmd |=> ((~readyVec & $past(readyVec)) == '0)); // R6

  AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rearmCmd && !frmValid) |=> ((readyVec & $past(wrBits)) == '0)); // R9

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrunFlag && !ovrClrCmd) |=> overrunFlag); // R8

  AST_SUMMARY_VIEW: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_SUMMARY) |-> (sumBits == readyVec)); // R10

endmodule

bind rxmbx_top rxmbx_checker i_checker (
  .clk         (clk),
  .rstN        (rstN),
  .frmValid    (frmValid),
  .busWrEn     (busWrEn),
  .busAddr     (busAddr),
  .wrBits      (busWdata[rxmbx_pkg::MbxNum-1:0]),
  .sumBits     (busRdata[rxmbx_pkg::MbxNum-1:0]),
  .readyVec    (readyVec),
  .overrunFlag (overrunFlag)
);

// File: tb/test_rxmbx_top.sv
module test_rxmbx_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frmValid = 1'b0;
  logic        frmExt = 1'b0;
  logic [28:0] frmId = '0;
  logic        frmRtr = 1'b0;
  logic [3:0]  frmLen = '0;
  logic [63:0] frmData = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rxmbx_top i_rxmbx_top (
    .clk(clk), .rstN(rstN), .frmValid(frmValid), .frmExt(frmExt),
    .frmId(frmId), .frmRtr(frmRtr), .frmLen(frmLen), .frmData(frmData),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata)
  );

  typedef struct packed {
    logic        ext;
    logic [28:0] id;
    logic        rtr;
    logic [3:0]  len;
    logic [4:0]  expMb;
    logic        expLost;
    logic [15:0] expSum;
  } vec_t;

  localparam logic [4:0] DROP = 5'd31;
  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 29'h123,      1'b0, 4'd8, 5'd0, 1'b0, 16'h0001},
    '{1'b1, 29'h1ABCDEF0, 1'b0, 4'd4, 5'd3, 1'b0, 16'h0009},
    '{1'b0, 29'h7FF,      1'b1, 4'd0, 5'd1, 1'b0, 16'h000B},
    '{1'b0, 29'h001,      1'b0, 4'd2, 5'd2, 1'b0, 16'h000F},
    '{1'b0, 29'h055,      1'b0, 4'd3, 5'd4, 1'b0, 16'h001F},
    '{1'b0, 29'h0AA,      1'b0, 4'd5, 5'd4, 1'b1, 16'h001F},
    '{1'b1, 29'h7,        1'b0, 4'd1, DROP, 1'b0, 16'h001F}
  };

  function automatic logic [7:0] mbAddr(input int mb, input int ofs);
    return 8'(8'h40 + mb * 8 + ofs);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic sendFrame(input logic ext, input logic [28:0] id, input logic rtr,
                           input logic [3:0] len, input logic [63:0] data);
    @(negedge clk);
    frmExt = ext; frmId = id; frmRtr = rtr; frmLen = len; frmData = data;
    frmValid = 1'b1;
    @(negedge clk);
    frmValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] expId;
    logic [63:0] dat;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(8'h00, rd); check("R1 summary", rd, 32'h0);
    busRead(8'h01, rd); check("R1 overrun", rd, 32'h0);
    busRead(mbAddr(0, 0), rd); check("R1 mode", rd, 32'h0);
    busRead(mbAddr(4, 2), rd); check("R1 status", rd, 32'h0);

    // configuration: 0..2 rx std, 3 rx ext, 4 overwrite std, 5 transmit
    for (int m = 0; m < 3; m++) busWrite(mbAddr(m, 0), 32'h0100_0000);
    busWrite(mbAddr(3, 0), 32'h0100_0000);
    busWrite(mbAddr(3, 1), 32'h2000_0000);
    busWrite(mbAddr(4, 0), 32'h0200_0000);
    busWrite(mbAddr(5, 0), 32'h0300_0000);
    busRead(mbAddr(4, 0), rd); check("R2 mode overwrite", rd, 32'h0200_0000);
    busRead(mbAddr(5, 0), rd); check("R2 mode transmit", rd, 32'h0300_0000);

    for (int v = 0; v < NVEC; v++) begin
      dat = 64'h0807_0605_0403_0201 + 64'(v);
      sendFrame(VECS[v].ext, VECS[v].id, VECS[v].rtr, VECS[v].len, dat);
      busRead(8'h00, rd); check("R3 R10 summary", rd, {16'h0, VECS[v].expSum});
      if (VECS[v].expMb != DROP) begin
        busRead(mbAddr(int'(VECS[v].expMb), 2), rd);
        check("R6 R7 status", rd,
              {7'b0, VECS[v].expLost, 1'b1, 2'b0, VECS[v].rtr, VECS[v].len, 16'h0});
        expId = VECS[v].ext ? (32'h2000_0000 | {3'b0, VECS[v].id})
                            : {3'b0, VECS[v].id[10:0], 18'h0};
        busRead(mbAddr(int'(VECS[v].expMb), 1), rd); check("R5 id", rd, expId);
        busRead(mbAddr(int'(VECS[v].expMb), 3), rd); check("R5 data low", rd, dat[31:0]);
        busRead(mbAddr(int'(VECS[v].expMb), 4), rd); check("R5 data high", rd, dat[63:32]);
      end else begin
        busRead(8'h01, rd); check("R8 overrun set", rd, 32'h1);
      end
    end

    // R11 status write ignored
    busWrite(mbAddr(0, 2), 32'h0);
    busRead(mbAddr(0, 2), rd); check("R11 status kept", rd, 32'h0088_0000);

    // R9 rearm mailboxes 0 and 4
    busWrite(8'h02, 32'h0000_0011);
    busRead(8'h00, rd); check("R9 summary after rearm", rd, 32'h0000_000E);
    busRead(mbAddr(4, 2), rd); check("R9 lost cleared", rd, 32'h0005_0000);

    // R3 lowest free slot reused
    sendFrame(1'b0, 29'h321, 1'b0, 4'd6, 64'h1111_2222_3333_4444);
    busRead(8'h00, rd); check("R3 lands in mailbox 0", rd, 32'h0000_000F);

    // R8 overrun clear by write of 1
    busWrite(8'h01, 32'h1);
    busRead(8'h01, rd); check("R8 overrun cleared", rd, 32'h0);

    // R2 transmit mailbox never captures; R7 overwrite again
    sendFrame(1'b0, 29'h010, 1'b0, 4'd1, 64'h0);
    sendFrame(1'b0, 29'h020, 1'b0, 4'd2, 64'h0);
    busRead(8'h00, rd); check("R2 transmit mailbox idle", rd, 32'h0000_001F);
    busRead(mbAddr(5, 2), rd); check("R2 transmit status", rd, 32'h0);
    busRead(mbAddr(4, 2), rd); check("R7 overwrite lost", rd, 32'h0182_0000);

    // R4 standard frame may not enter the free extended mailbox
    busWrite(8'h02, 32'h0000_0008);
    sendFrame(1'b0, 29'h030, 1'b0, 4'd3, 64'h0);
    busRead(8'h00, rd); check("R4 ext mailbox untouched", rd, 32'h0000_0017);
    busRead(mbAddr(4, 1), rd); check("R4 overwrite id", rd, 32'h00C0_0000);
    busRead(8'h01, rd); check("R8 no overrun on overwrite", rd, 32'h0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule